// File: doc/BRIEF.md
# Accumulator Field Extract Unit

This unit turns a 64-bit accumulator value into a 32-bit result by one of two routes. The shift route shifts the accumulator right arithmetically and keeps the low 32 bits. It can round before the shift, and it can saturate the result to the signed 32-bit limits. It records an out-of-range condition in a sticky flag bit of a 32-bit control word. The field route takes a bit-field whose top bit is a 6-bit position kept in the control word and whose width is given by the size amount. It reports whether the field fits, and one variant moves the position down past the extracted field.

The caller supplies the accumulator value, the amount, the operation code, the round and saturate enables and the current control word, together with a one-cycle input strobe. One clock later the unit presents the 32-bit result and the complete updated control word. The caller writes that word back into its own copy. Accumulator storage lives outside the unit.

Top module: `acc_extract_unit`

## Requirements
- R1: Results are registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` and `ctrl_out` change only on a strobed cycle and otherwise hold. Reset clears `out_valid`, `result` and `ctrl_out` to zero.
- R2: With `op_sel` = 2'b00 (shift extract), the shift count is `amount[4:0]`, and `amount[5]` is ignored. The result is the low 32 bits of the accumulator shifted right arithmetically. A count of zero passes the accumulator's low 32 bits through.
- R3: With `round_en` high and a nonzero count n, 2^(n-1) is added to the accumulator before the shift. With a zero count, no rounding is applied.
- R4: If rounding turns a positive accumulator negative, `ctrl_out[23]` is set. If `sat_en` is also high, the value before the shift is replaced by the largest positive 64-bit number.
- R5: If the accumulator lies outside the signed 32-bit range, `ctrl_out[23]` is set. If `sat_en` is high, a shifted value that does not fit is clamped to 32'h7FFF_FFFF or 32'h8000_0000 according to its sign. Otherwise the value is truncated. Bit 23 is never cleared by the unit.
- R6: With `op_sel` = 2'b01 or 2'b10 (field extract), the position is `ctrl_in[5:0]` and the size is `amount[4:0]`. The field is valid when position >= size. The result is then accumulator bits [position : position-size], zero-extended to 32 bits.
- R7: A valid field extract clears `ctrl_out[14]`. An invalid one returns zero and sets `ctrl_out[14]`.
- R8: With `op_sel` = 2'b10 and a valid field, `ctrl_out[5:0]` becomes position-size-1, or 63 when position equals size. An invalid field leaves the position unchanged.
- R9: Control bits that an operation does not name pass from `ctrl_in` to `ctrl_out` unchanged. For the shift route these are all bits except 23. For the field route they are all bits except 14 and, for the decrementing variant, bits [5:0].
- R10: `op_sel` = 2'b11 returns a zero result and passes `ctrl_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 00 shift, 01 field, 10 field with decrement, 11 none |
| acc_in | input | 64 | Accumulator value |
| amount | input | 6 | Shift count or field size (low 5 bits used) |
| round_en | input | 1 | Round before shifting |
| sat_en | input | 1 | Saturate to 32 bits |
| ctrl_in | input | 32 | Current control word |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Extracted value |
| ctrl_out | output | 32 | Updated control word |

## Verification
Two pairs of effects can land on a single operation. In the decrementing field extract, the validity check and the wrap of the position to 63 coincide when position equals size. The bench sets that boundary directly and expects bit 14 clear together with a position of 63. On the shift route, the rounding carry into the sign bit and the 32-bit range overflow coincide for an accumulator of the largest positive 64-bit value with rounding on. That case is run both with and without saturation, and the result is expected to be 32'h7FFF_FFFF and zero respectively, with bit 23 set both times.

// File: rtl/acx_pkg.sv
package acx_pkg;
  typedef enum logic [1:0] {
    OP_SHIFT     = 2'b00,
    OP_FIELD     = 2'b01,
    OP_FIELD_DEC = 2'b10,
    OP_NONE      = 2'b11
  } acx_op_e;

  // control-word bit positions the block writes
  localparam int OVF_BIT  = 23;
  localparam int BAD_BIT  = 14;
  localparam int POS_LSB  = 0;
endpackage

// File: rtl/acx_shift_path.sv
module acx_shift_path #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  parameter int SA_W  = 5
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [SA_W-1:0]  sa,
  input  logic             rnd_en,
  input  logic             sat_en,
  output logic [RES_W-1:0] res,
  output logic             ovf
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [RES_W-1:0] RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] ONE     = {{(ACC_W-1){1'b0}}, 1'b1};

  logic [ACC_W-1:0]        half;
  logic [ACC_W-1:0]        sum;
  logic [ACC_W-1:0]        pre;
  logic signed [ACC_W-1:0] shifted;
  logic                    rnd_ovf;
  logic                    range_ovf;
  logic                    fits;

  always_comb begin
    half      = (sa == '0) ? '0 : (ONE << (sa - SA_W'(1)));
    sum       = rnd_en ? (acc + half) : acc;
    rnd_ovf   = rnd_en && (sa != '0) && !acc[ACC_W-1] && (acc != '0) && sum[ACC_W-1];
    pre       = (rnd_ovf && sat_en) ? ACC_MAX : sum;
    shifted   = $signed(pre) >>> sa;
    range_ovf = !((&acc[ACC_W-1:RES_W-1]) || (~|acc[ACC_W-1:RES_W-1]));
    ovf       = rnd_ovf || range_ovf;
    fits      = (&shifted[ACC_W-1:RES_W-1]) || (~|shifted[ACC_W-1:RES_W-1]);
    if (ovf && sat_en && !fits) res = shifted[ACC_W-1] ? RES_MIN : RES_MAX;
    else                        res = shifted[RES_W-1:0];
  end
endmodule

// File: rtl/acx_field_path.sv
module acx_field_path #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  parameter int POS_W = 6,
  parameter int SZ_W  = 5
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [POS_W-1:0] pos,
  input  logic [SZ_W-1:0]  size,
  output logic [RES_W-1:0] res,
  output logic             ok,
  output logic [POS_W-1:0] next_pos
);
  localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

  logic [POS_W-1:0] lsb;
  logic [ACC_W-1:0] field;
  logic [ACC_W-1:0] mask;
  logic [ACC_W-1:0] kept;

  always_comb begin
    ok       = pos >= POS_W'(size);
    lsb      = pos - POS_W'(size);
    field    = acc >> lsb;
    mask     = (ONE << (POS_W'(size) + POS_W'(1))) - ONE;
    kept     = field & mask;
    res      = ok ? kept[RES_W-1:0] : '0;
    // position minus (size+1); the 6-bit wrap turns -1 into 63
    next_pos = lsb - POS_W'(1);
  end
endmodule

// File: rtl/acc_extract_unit.sv
module acc_extract_unit
  import acx_pkg::*;
#(
  parameter int ACC_W  = 64,
  parameter int RES_W  = 32,
  parameter int AMT_W  = 6,
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [AMT_W-1:0]  amount,
  input  logic              round_en,
  input  logic              sat_en,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic              out_valid,
  output logic [RES_W-1:0]  result,
  output logic [CTRL_W-1:0] ctrl_out
);
  localparam int POS_W = $clog2(ACC_W);
  localparam int SZ_W  = $clog2(RES_W);

  logic [RES_W-1:0]  sh_res;
  logic              sh_ovf;
  logic [RES_W-1:0]  fl_res;
  logic              fl_ok;
  logic [POS_W-1:0]  fl_next;
  logic [RES_W-1:0]  res_d;
  logic [CTRL_W-1:0] ctrl_d;
  acx_op_e           op;

  acx_shift_path #(.ACC_W(ACC_W), .RES_W(RES_W), .SA_W(SZ_W)) u_shift (
    .acc(acc_in), .sa(amount[SZ_W-1:0]), .rnd_en(round_en), .sat_en(sat_en),
    .res(sh_res), .ovf(sh_ovf)
  );

  acx_field_path #(.ACC_W(ACC_W), .RES_W(RES_W), .POS_W(POS_W), .SZ_W(SZ_W)) u_field (
    .acc(acc_in), .pos(ctrl_in[POS_LSB +: POS_W]), .size(amount[SZ_W-1:0]),
    .res(fl_res), .ok(fl_ok), .next_pos(fl_next)
  );

  always_comb begin
    op     = acx_op_e'(op_sel);
    ctrl_d = ctrl_in;
    res_d  = '0;
    case (op)
      OP_SHIFT: begin
        res_d = sh_res;
        if (sh_ovf) ctrl_d[OVF_BIT] = 1'b1;
      end
      OP_FIELD, OP_FIELD_DEC: begin
        res_d           = fl_res;
        ctrl_d[BAD_BIT] = !fl_ok;
        if (op == OP_FIELD_DEC && fl_ok) ctrl_d[POS_LSB +: POS_W] = fl_next;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ctrl_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= res_d;
        ctrl_out <= ctrl_d;
      end
    end
  end
endmodule

// File: rtl/acx_checker.sv
module acx_checker #(
  parameter int ACC_W  = 64,
  parameter int RES_W  = 32,
  parameter int AMT_W  = 6,
  parameter int CTRL_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        op_sel,
  input logic [ACC_W-1:0]  acc_in,
  input logic [AMT_W-1:0]  amount,
  input logic [CTRL_W-1:0] ctrl_in,
  input logic              out_valid,
  input logic [RES_W-1:0]  result,
  input logic [CTRL_W-1:0] ctrl_out
);
  localparam int POS_W = $clog2(ACC_W);
  localparam int SZ_W  = $clog2(RES_W);

  logic field_op;
  logic acc_wide;
  assign field_op = (op_sel == 2'b01) || (op_sel == 2'b10);
  assign acc_wide = !((&acc_in[ACC_W-1:RES_W-1]) || (~|acc_in[ACC_W-1:RES_W-1]));

  assert_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(ctrl_out)));
  assert_range_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b00 && acc_wide) |=> ctrl_out[23]);
  assert_field_width_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && field_op) |=> ((result >> (int'($past(amount[SZ_W-1:0])) + 1)) == '0));
  assert_field_bad_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && field_op && ctrl_in[POS_W-1:0] < POS_W'(amount[SZ_W-1:0]))
      |=> (result == '0 && ctrl_out[14]));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b10 && ctrl_in[POS_W-1:0] == POS_W'(amount[SZ_W-1:0]))
      |=> (ctrl_out[POS_W-1:0] == {POS_W{1'b1}} && !ctrl_out[14]));
  assert_shift_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b00) |=> (ctrl_out[22:0] == $past(ctrl_in[22:0])));
  assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11) |=> (result == '0 && ctrl_out == $past(ctrl_in)));
endmodule

bind acc_extract_unit acx_checker #(
  .ACC_W(ACC_W), .RES_W(RES_W), .AMT_W(AMT_W), .CTRL_W(CTRL_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .acc_in(acc_in),
  .amount(amount), .ctrl_in(ctrl_in), .out_valid(out_valid), .result(result),
  .ctrl_out(ctrl_out)
);

// File: tb/sim_acc_extract_unit.sv
`timescale 1ns/1ps
module sim_acc_extract_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic [63:0] acc_in;
  logic [5:0]  amount;
  logic        round_en;
  logic        sat_en;
  logic [31:0] ctrl_in;
  logic        out_valid;
  logic [31:0] result;
  logic [31:0] ctrl_out;

  int total = 0;
  int bad   = 0;

  localparam logic [63:0] PAT = 64'hFEDC_BA98_7654_3210;

  always #2 clk = ~clk;

  acc_extract_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel), .acc_in(acc_in),
    .amount(amount), .round_en(round_en), .sat_en(sat_en), .ctrl_in(ctrl_in),
    .out_valid(out_valid), .result(result), .ctrl_out(ctrl_out)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one strobed operation; outputs are sampled one negedge after the capture edge
  task automatic run(input string req, input logic [1:0] op, input logic [63:0] acc,
                     input logic [5:0] amt, input logic rnd, input logic sat,
                     input logic [31:0] ctl, input logic [31:0] exp_res,
                     input logic [31:0] exp_ctl);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; acc_in = acc; amount = amt;
    round_en = rnd; sat_en = sat; ctrl_in = ctl;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "out_valid", {31'd0, out_valid}, 32'd1);
    check(req, "result", result, exp_res);
    check(req, "ctrl_out", ctrl_out, exp_ctl);
  endtask

  task automatic t_reset;
    check("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1", "reset result", result, 32'd0);
    check("R1", "reset ctrl_out", ctrl_out, 32'd0);
  endtask

  task automatic t_shift;
    run("R2", 2'b00, 64'h0000_0000_1234_5678, 6'd4, 0, 0, 32'h0, 32'h0123_4567, 32'h0);
    run("R2", 2'b00, 64'hFFFF_FFFF_8000_0001, 6'd0, 0, 0, 32'h0, 32'h8000_0001, 32'h0);
    run("R2", 2'b00, 64'h0000_0000_0000_0100, 6'b100100, 0, 0, 32'h0, 32'h0000_0010, 32'h0);
    run("R2", 2'b00, 64'hFFFF_FFFF_FFFF_FF00, 6'd4, 0, 0, 32'h0, 32'hFFFF_FFF0, 32'h0);
  endtask

  task automatic t_round;
    run("R3", 2'b00, 64'd24, 6'd4, 1, 0, 32'h0, 32'd2, 32'h0);
    run("R3", 2'b00, 64'd24, 6'd4, 0, 0, 32'h0, 32'd1, 32'h0);
    run("R3", 2'b00, 64'hFFFF_FFFF_FFFF_FFE8, 6'd4, 1, 0, 32'h0, 32'hFFFF_FFFF, 32'h0);
    run("R3", 2'b00, 64'd7, 6'd0, 1, 0, 32'h0, 32'd7, 32'h0);
  endtask

  task automatic t_round_ovf;
    // rounding carry and range overflow on the same operation
    run("R4", 2'b00, 64'h7FFF_FFFF_FFFF_FFFF, 6'd1, 1, 1, 32'h0, 32'h7FFF_FFFF, 32'h0080_0000);
    run("R4", 2'b00, 64'h7FFF_FFFF_FFFF_FFFF, 6'd1, 1, 0, 32'h0, 32'h0000_0000, 32'h0080_0000);
  endtask

  task automatic t_range;
    run("R5", 2'b00, 64'h0000_0001_0000_0000, 6'd0, 0, 1, 32'h0, 32'h7FFF_FFFF, 32'h0080_0000);
    run("R5", 2'b00, 64'h0000_0001_0000_0000, 6'd0, 0, 0, 32'h0, 32'h0000_0000, 32'h0080_0000);
    run("R5", 2'b00, 64'hFFFF_FFFE_0000_0000, 6'd0, 0, 1, 32'h0, 32'h8000_0000, 32'h0080_0000);
    run("R5", 2'b00, 64'h0000_0001_0000_0000, 6'd4, 0, 1, 32'h0, 32'h1000_0000, 32'h0080_0000);
    // sticky bit 23 and other bits kept by a shift that does not overflow (R9)
    run("R5", 2'b00, 64'd5, 6'd0, 0, 1, 32'h0080_403F, 32'd5, 32'h0080_403F);
  endtask

  task automatic t_field;
    run("R6", 2'b01, PAT, 6'd7, 0, 0, 32'h0000_401F, 32'h0000_0076, 32'h0000_001F);
    run("R6", 2'b01, PAT, 6'd31, 0, 0, 32'h0000_003F, 32'hFEDC_BA98, 32'h0000_003F);
    run("R6", 2'b01, PAT, 6'd4, 0, 0, 32'h0000_0004, 32'h0000_0010, 32'h0000_0004);
    run("R6", 2'b01, PAT, 6'b100011, 0, 0, 32'h0000_0007, 32'h0000_0001, 32'h0000_0007);
  endtask

  task automatic t_field_bad;
    run("R7", 2'b01, PAT, 6'd5, 0, 0, 32'hA000_0002, 32'h0, 32'hA000_4002);
    run("R9", 2'b01, PAT, 6'd5, 1, 1, 32'hA080_0002, 32'h0, 32'hA080_4002);
  endtask

  task automatic t_decrement;
    run("R8", 2'b10, PAT, 6'd7, 0, 0, 32'h0000_4028, 32'h0000_004C, 32'h0000_0020);
    run("R8", 2'b10, PAT, 6'd5, 0, 0, 32'h0000_0005, 32'h0000_0010, 32'h0000_003F);
    run("R8", 2'b10, PAT, 6'd2, 0, 0, 32'h0000_0001, 32'h0, 32'h0000_4001);
  endtask

  task automatic t_reserved;
    run("R10", 2'b11, PAT, 6'd3, 1, 1, 32'h1234_5678, 32'h0, 32'h1234_5678);
  endtask

  task automatic t_idle;
    run("R1", 2'b00, 64'd99, 6'd0, 0, 0, 32'h0000_0100, 32'd99, 32'h0000_0100);
    acc_in = PAT; op_sel = 2'b11; ctrl_in = 32'hFFFF_FFFF;
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R1", "idle out_valid", {31'd0, out_valid}, 32'd0);
    check("R1", "idle result", result, 32'd99);
    check("R1", "idle ctrl_out", ctrl_out, 32'h0000_0100);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_sel = 2'b00; acc_in = '0; amount = '0;
    round_en = 1'b0; sat_en = 1'b0; ctrl_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_shift();
    t_round();
    t_round_ovf();
    t_range();
    t_field();
    t_field_bad();
    t_decrement();
    t_reserved();
    t_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule